// File: doc/BRIEF.md
# Associative DRAM Command Reorder Queue

This block holds pending DRAM requests in front of a command sequencer and decides which one goes next. Each request carries a direction (read or write), a bank, a row and a column. It is written into any free slot of a fully associative store. Every cycle the block compares all stored requests at once against the open-row state it keeps for each bank. It then presents one DRAM command on its output: activate, precharge, read or write.

The selection favours, in this order:
- requests whose age has reached a programmable limit;
- requests that hit the row already open in their bank;
- requests whose direction matches the last column command, which avoids a bus turnaround;
- the request waiting longest.

A request that misses its bank's open row is served in steps. The block first closes the row with a precharge, then waits a minimum idle interval, then opens the new row with an activate, and only then issues the column command. Two requests to the same bank, row and column always leave in the order they arrived.

Both data-carrying interfaces use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` falls only when every slot is occupied. The command output holds its contents steady while `cmd_valid` is high and `cmd_ready` is low. The command counts as issued only on a cycle where both are high. The sender may not withdraw or change a request while its `req_valid` is high and `req_ready` is low. `age_limit` is a plain control input.

Top module: `rq_reorder_queue`

## Requirements
- R1: `req_ready` is high exactly when fewer than DEPTH requests are pending. A request stays pending from the cycle it is accepted until its read or write command is taken.
- R2: Command codes on `cmd_op` are 0 read, 1 write, 2 activate, 3 precharge. Every accepted request is issued as exactly one read (if its write flag is 0) or write (if 1), carrying its own bank, row and column.
- R3: While `cmd_valid` is high and `cmd_ready` is low, the next cycle still has `cmd_valid` high with the same op, bank, row and column.
- R4: A read or write is issued only to a bank whose open row equals the command's row.
- R5: A precharge goes only to an open bank. An activate goes only to an idle bank, and no sooner than T_RP cycles after the last precharge taken for that bank.
- R6: A request that hits its bank's open row is issued before an older request that misses in the same bank.
- R7: Among open-row hits, a request whose direction matches the last issued read/write is taken before an older request of the other direction.
- R8: Among requests equal on age promotion, row hit and direction, the oldest is served first.
- R9: A request whose age (cycles since acceptance) is at least `age_limit` ranks above any request below that age, whether or not it hits.
- R10: Two requests with the same bank, row and column leave in arrival order, even when the later one would otherwise rank higher.
- R11: After reset `cmd_valid` is low, `req_ready` is high, every bank is idle (the first command for a new request is an activate), and the last direction counts as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| age_limit | input | AGE_W | Age at which a request is promoted above all others |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A slot is free; request taken when both high |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer takes the command when both high |
| cmd_op | output | 2 | 0 read, 1 write, 2 activate, 3 precharge |
| cmd_bank | output | clog2(NUM_BANKS) | Command bank |
| cmd_row | output | ROW_W | Row (meaningful for activate, read, write) |
| cmd_col | output | COL_W | Column (meaningful for read, write) |

## Verification
The properties assume the sequencer alone decides when a command is taken. They also assume a pending request is never withdrawn, and that `age_limit` changes only while the queue is quiet, so rank comparisons stay consistent. The stimulus holds each request steady until it is accepted and drives `cmd_ready` as low, high or random from a single process. It changes `age_limit` only between directed phases, with no request in flight. The random phase draws from four rows and four columns per bank so that same-address pairs and row conflicts are frequent.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_ACT = 2'd2,
    OP_PRE = 2'd3
  } rq_op_e;
endpackage

// File: rtl/rq_bank_tracker.sv
module rq_bank_tracker
  import rq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int T_RP      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int TW       = $clog2(T_RP + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd_valid,
  input  rq_op_e                          upd_op,
  input  logic [BANK_W-1:0]               upd_bank,
  input  logic [ROW_W-1:0]                upd_row,
  output logic [NUM_BANKS-1:0]            bank_open,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
  output logic [NUM_BANKS-1:0]            bank_rdy
);
  localparam logic [TW-1:0] RELOAD = TW'(T_RP - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] idle_tmr;
    logic          sel;
    assign sel = upd_valid && (upd_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        bank_row[b]  <= '0;
        idle_tmr     <= '0;
      end else if (sel && upd_op == OP_PRE) begin
        bank_open[b] <= 1'b0;
        idle_tmr     <= RELOAD;
      end else begin
        if (sel && upd_op == OP_ACT) begin
          bank_open[b] <= 1'b1;
          bank_row[b]  <= upd_row;
        end
        if (idle_tmr != '0) idle_tmr <= idle_tmr - 1'b1;
      end
    end

    assign bank_rdy[b] = (idle_tmr == '0);
  end
endmodule

// File: rtl/rq_entry_store.sv
module rq_entry_store #(
  parameter int DEPTH   = 32,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int AGE_W   = 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ins_en,
  input  logic                        ins_write,
  input  logic [BANK_W-1:0]           ins_bank,
  input  logic [ROW_W-1:0]            ins_row,
  input  logic [COL_W-1:0]            ins_col,
  input  logic                        rem_en,
  input  logic [IDX_W-1:0]            rem_idx,
  output logic [DEPTH-1:0]            ent_valid,
  output logic [DEPTH-1:0]            ent_write,
  output logic [DEPTH-1:0][BANK_W-1:0] ent_bank,
  output logic [DEPTH-1:0][ROW_W-1:0] ent_row,
  output logic [DEPTH-1:0][COL_W-1:0] ent_col,
  output logic [DEPTH-1:0][AGE_W-1:0] ent_age,
  output logic [DEPTH-1:0]            ent_blocked,
  output logic                        free_avail
);
  logic [IDX_W-1:0]           free_idx;
  logic [DEPTH-1:0]           rem_mask;
  logic [DEPTH-1:0]           same_addr;
  logic [DEPTH-1:0][DEPTH-1:0] dep;

  always_comb begin
    free_idx   = '0;
    free_avail = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx   = IDX_W'(i);
        free_avail = 1'b1;
      end
    end
  end

  always_comb begin
    rem_mask = '0;
    if (rem_en) rem_mask[rem_idx] = 1'b1;
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_match
    assign same_addr[j] = ent_valid[j] && !rem_mask[j] &&
                          ent_bank[j] == ins_bank &&
                          ent_row[j] == ins_row && ent_col[j] == ins_col;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic take;
    assign take = ins_en && (free_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_write[i] <= 1'b0;
        ent_bank[i]  <= '0;
        ent_row[i]   <= '0;
        ent_col[i]   <= '0;
        ent_age[i]   <= '0;
        dep[i]       <= '0;
      end else if (take) begin
        ent_valid[i] <= 1'b1;
        ent_write[i] <= ins_write;
        ent_bank[i]  <= ins_bank;
        ent_row[i]   <= ins_row;
        ent_col[i]   <= ins_col;
        ent_age[i]   <= '0;
        dep[i]       <= same_addr;
      end else if (rem_mask[i]) begin
        ent_valid[i] <= 1'b0;
        dep[i]       <= '0;
      end else begin
        if (ent_valid[i] && ent_age[i] != '1) ent_age[i] <= ent_age[i] + 1'b1;
        dep[i] <= dep[i] & ~rem_mask;
      end
    end

    assign ent_blocked[i] = |dep[i];
  end
endmodule

// File: rtl/rq_picker.sv
module rq_picker
  import rq_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int AGE_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int KEY_W    = AGE_W + 3
) (
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0]             ent_write,
  input  logic [DEPTH-1:0][BANK_W-1:0] ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]  ent_row,
  input  logic [DEPTH-1:0][AGE_W-1:0]  ent_age,
  input  logic [DEPTH-1:0]             ent_blocked,
  input  logic [NUM_BANKS-1:0]         bank_open,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
  input  logic [NUM_BANKS-1:0]         bank_rdy,
  input  logic                         last_write,
  input  logic [AGE_W-1:0]             age_limit,
  output logic                         pick_valid,
  output logic [IDX_W-1:0]             pick_idx,
  output rq_op_e                       pick_op
);
  logic [DEPTH-1:0]            hit_v;
  logic [DEPTH-1:0]            elig_v;
  logic [DEPTH-1:0][KEY_W-1:0] key_v;
  rq_op_e                      op_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rank
    logic is_open, urgent, same_dir;
    assign is_open  = bank_open[ent_bank[i]];
    assign hit_v[i] = is_open && (bank_row[ent_bank[i]] == ent_row[i]);
    assign urgent   = ent_age[i] >= age_limit;
    assign same_dir = ent_write[i] == last_write;
    assign elig_v[i] = ent_valid[i] && !ent_blocked[i] &&
                       (is_open || bank_rdy[ent_bank[i]]);
    assign key_v[i] = {urgent, hit_v[i], same_dir, ent_age[i]};
    assign op_v[i]  = hit_v[i] ? (ent_write[i] ? OP_WR : OP_RD)
                               : (is_open ? OP_PRE : OP_ACT);
  end

  always_comb begin
    logic [KEY_W-1:0] best;
    best       = '0;
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_op    = OP_RD;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig_v[i] && (!pick_valid || key_v[i] > best)) begin
        pick_valid = 1'b1;
        best       = key_v[i];
        pick_idx   = IDX_W'(i);
        pick_op    = op_v[i];
      end
    end
  end
endmodule

// File: rtl/rq_reorder_queue.sv
module rq_reorder_queue
  import rq_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int AGE_W     = 8,
  parameter int T_RP      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGE_W-1:0]  age_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  logic [DEPTH-1:0]             ent_valid, ent_write, ent_blocked;
  logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
  logic [DEPTH-1:0][COL_W-1:0]  ent_col;
  logic [DEPTH-1:0][AGE_W-1:0]  ent_age;
  logic [NUM_BANKS-1:0]             bank_open, bank_rdy;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_row;
  logic             free_avail, pick_valid, last_write, held, fire, col_fire;
  logic [IDX_W-1:0] pick_idx, held_idx, out_idx;
  rq_op_e           pick_op, held_op, out_op;

  assign req_ready = free_avail;
  assign out_idx   = held ? held_idx : pick_idx;
  assign out_op    = held ? held_op  : pick_op;
  assign cmd_valid = held || pick_valid;
  assign cmd_op    = out_op;
  assign cmd_bank  = ent_bank[out_idx];
  assign cmd_row   = ent_row[out_idx];
  assign cmd_col   = ent_col[out_idx];
  assign fire      = cmd_valid && cmd_ready;
  assign col_fire  = fire && (out_op == OP_RD || out_op == OP_WR);

  rq_entry_store #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_en(req_valid && req_ready), .ins_write(req_write),
    .ins_bank(req_bank), .ins_row(req_row), .ins_col(req_col),
    .rem_en(col_fire), .rem_idx(out_idx),
    .ent_valid(ent_valid), .ent_write(ent_write), .ent_bank(ent_bank),
    .ent_row(ent_row), .ent_col(ent_col), .ent_age(ent_age),
    .ent_blocked(ent_blocked), .free_avail(free_avail)
  );

  rq_bank_tracker #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RP(T_RP)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(fire), .upd_op(out_op), .upd_bank(cmd_bank), .upd_row(cmd_row),
    .bank_open(bank_open), .bank_row(bank_row), .bank_rdy(bank_rdy)
  );

  rq_picker #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .AGE_W(AGE_W)
  ) u_pick (
    .ent_valid(ent_valid), .ent_write(ent_write), .ent_bank(ent_bank),
    .ent_row(ent_row), .ent_age(ent_age), .ent_blocked(ent_blocked),
    .bank_open(bank_open), .bank_row(bank_row), .bank_rdy(bank_rdy),
    .last_write(last_write), .age_limit(age_limit),
    .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_op(pick_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= 1'b0;
      held_idx   <= '0;
      held_op    <= OP_RD;
      last_write <= 1'b0;
    end else begin
      if (fire) begin
        held <= 1'b0;
      end else if (cmd_valid) begin
        held     <= 1'b1;
        held_idx <= out_idx;
        held_op  <= out_op;
      end
      if (col_fire) last_write <= (out_op == OP_WR);
    end
  end
endmodule

// File: rtl/rq_reorder_queue_chk.sv
module rq_reorder_queue_chk #(
  parameter int DEPTH     = 32,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_RP      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int GW       = $clog2(T_RP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col
);
  logic [OCC_W-1:0]           occ;
  logic [NUM_BANKS-1:0]       sh_open;
  logic [ROW_W-1:0]           sh_row [NUM_BANKS];
  logic [GW-1:0]              gap [NUM_BANKS];
  logic fire, colf;

  assign fire = cmd_valid && cmd_ready;
  assign colf = fire && cmd_op[1] == 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      sh_open <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        sh_row[b] <= '0;
        gap[b]    <= GW'(T_RP);
      end
    end else begin
      occ <= occ + OCC_W'(req_valid && req_ready) - OCC_W'(colf);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (fire && cmd_bank == BANK_W'(b) && cmd_op == 2'd3) begin
          sh_open[b] <= 1'b0;
          gap[b]     <= GW'(1);
        end else begin
          if (fire && cmd_bank == BANK_W'(b) && cmd_op == 2'd2) begin
            sh_open[b] <= 1'b1;
            sh_row[b]  <= cmd_row;
          end
          if (gap[b] != GW'(T_RP)) gap[b] <= gap[b] + 1'b1;
        end
      end
    end
  end

  // R1
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (occ < OCC_W'(DEPTH)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                && $stable(cmd_row) && $stable(cmd_col));

  // R4
  col_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    colf |-> sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row);

  // R5
  pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 2'd3 |-> sh_open[cmd_bank]);

  // R5
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 2'd2 |-> !sh_open[cmd_bank] && gap[cmd_bank] >= GW'(T_RP));
endmodule

bind rq_reorder_queue rq_reorder_queue_chk #(
  .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
);

// File: tb/tb_rq_reorder_queue.sv
module tb_rq_reorder_queue;
  localparam int DEPTH = 32, NB = 8, ROW_W = 14, COL_W = 10, AGE_W = 8, T_RP = 4;
  localparam int BANK_W = $clog2(NB);
  localparam int RD = 0, WR = 1, ACT = 2, PRE = 3;

  logic clk = 0, rst_n = 0;
  logic [AGE_W-1:0] age_limit = '1;
  logic req_valid = 0, req_write = 0, cmd_ready = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_valid;
  logic [1:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  rq_reorder_queue #(.DEPTH(DEPTH), .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W),
                     .AGE_W(AGE_W), .T_RP(T_RP)) dut (
    .clk(clk), .rst_n(rst_n), .age_limit(age_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  int ready_mode = 0;  // 0 low, 1 high, 2 random

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (ready_mode == 0) cmd_ready = 0;
    else if (ready_mode == 1) cmd_ready = 1;
    else cmd_ready = ($urandom % 10) < 7;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fired-command log and bench scoreboard
  int log_n = 0;
  int log_op [256];
  int log_bank [256], log_row [256], log_col [256];
  int pend_n = 0;
  int p_wr [64], p_bank [64], p_row [64], p_col [64];
  bit sh_open [NB];
  int sh_row [NB];
  int pre_cyc [NB];
  bit stall_prev = 0;
  int s_op, s_bank, s_row, s_col;

  function automatic int find_pending(int b, int r, int c);
    for (int k = 0; k < pend_n; k++)
      if (p_bank[k] == b && p_row[k] == r && p_col[k] == c) return k;
    return -1;
  endfunction

  initial for (int b = 0; b < NB; b++) begin sh_open[b] = 0; sh_row[b] = 0; pre_cyc[b] = -1000; end

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)  // R3
        check(cmd_valid && cmd_op == s_op && cmd_bank == s_bank && cmd_row == s_row &&
              cmd_col == s_col, "R3 stall hold", {cmd_valid, cmd_op, cmd_bank},
              {1'b1, 2'(s_op), 3'(s_bank)});
      stall_prev = cmd_valid && !cmd_ready;
      s_op = cmd_op; s_bank = cmd_bank; s_row = cmd_row; s_col = cmd_col;
      if (req_valid && req_ready && pend_n < 64) begin
        p_wr[pend_n] = req_write; p_bank[pend_n] = req_bank;
        p_row[pend_n] = req_row; p_col[pend_n] = req_col; pend_n++;
      end
      if (cmd_valid && cmd_ready) begin
        if (log_n < 256) begin
          log_op[log_n] = cmd_op; log_bank[log_n] = cmd_bank;
          log_row[log_n] = cmd_row; log_col[log_n] = cmd_col; log_n++;
        end
        if (cmd_op == RD || cmd_op == WR) begin
          int k;
          check(sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row, "R4 column to open row",
                sh_row[cmd_bank], cmd_row);
          k = find_pending(cmd_bank, cmd_row, cmd_col);
          // R2 and R10: earliest same-address pending request must match direction
          check(k >= 0 && p_wr[k] == (cmd_op == WR), "R2/R10 issue match",
                (k >= 0) ? p_wr[k] : -1, cmd_op);
          if (k >= 0) begin
            for (int m = k; m < pend_n - 1; m++) begin
              p_wr[m] = p_wr[m+1]; p_bank[m] = p_bank[m+1];
              p_row[m] = p_row[m+1]; p_col[m] = p_col[m+1];
            end
            pend_n--;
          end
        end else if (cmd_op == ACT) begin
          check(!sh_open[cmd_bank] && (cyc - pre_cyc[cmd_bank]) >= T_RP,
                "R5 activate timing", cyc - pre_cyc[cmd_bank], T_RP);
          sh_open[cmd_bank] = 1; sh_row[cmd_bank] = cmd_row;
        end else begin
          check(sh_open[cmd_bank], "R5 precharge open bank", sh_open[cmd_bank], 1);
          sh_open[cmd_bank] = 0; pre_cyc[cmd_bank] = cyc;
        end
      end
    end
  end

  task automatic push(input int w, input int b, input int r, input int c);
    bit acc;
    req_valid = 1; req_write = w[0]; req_bank = BANK_W'(b);
    req_row = ROW_W'(r); req_col = COL_W'(c);
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_log(input int n);
    for (int t = 0; t < 300 && log_n < n; t++) idle(1);
  endtask

  task automatic expect_cmd(input int k, input int op, input int b, input int r,
                            input int c, input string tag);
    bit ok;
    ok = (k < log_n) && log_op[k] == op && log_bank[k] == b &&
         (op == PRE || log_row[k] == r) && (op > WR || log_col[k] == c);
    check(ok, tag, (k < log_n) ? {log_op[k], log_bank[k], log_row[k]} : -1, {op, b, r});
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(cmd_valid == 0, "R11 cmd_valid after reset", cmd_valid, 0);
    check(req_ready == 1, "R11 req_ready after reset", req_ready, 1);
    @(posedge clk); #1;

    // R11/R2: idle bank needs an activate first
    log_n = 0; ready_mode = 1;
    push(RD, 0, 5, 1);
    wait_log(2);
    expect_cmd(0, ACT, 0, 5, 0, "R11 first command activate");
    expect_cmd(1, RD, 0, 5, 1, "R2 read issued");

    // R6: hit before older miss; R5 miss path
    ready_mode = 0; idle(2); log_n = 0;
    push(RD, 1, 2, 0); push(RD, 0, 7, 0); push(RD, 0, 5, 3);
    idle(2); ready_mode = 1;
    wait_log(6);
    expect_cmd(0, ACT, 1, 2, 0, "R6 latched activate");
    expect_cmd(1, RD, 1, 2, 0, "R8 oldest hit first");
    expect_cmd(2, RD, 0, 5, 3, "R6 hit before older miss");
    expect_cmd(3, PRE, 0, 0, 0, "R5 precharge for miss");
    expect_cmd(4, ACT, 0, 7, 0, "R5 activate after precharge");
    expect_cmd(5, RD, 0, 7, 0, "R2 miss read issued");

    // R7 direction preference, R8 age order
    ready_mode = 0; idle(2); log_n = 0;
    push(RD, 2, 1, 0); push(WR, 0, 7, 1); push(RD, 0, 7, 2);
    idle(2); ready_mode = 1;
    wait_log(4);
    expect_cmd(1, RD, 2, 1, 0, "R8 oldest same rank");
    expect_cmd(2, RD, 0, 7, 2, "R7 same direction first");
    expect_cmd(3, WR, 0, 7, 1, "R7 turnaround last");

    // R10 same-address order (last direction is write)
    ready_mode = 0; idle(2); log_n = 0;
    push(RD, 3, 1, 0); push(RD, 0, 7, 9); push(WR, 0, 7, 9);
    idle(2); ready_mode = 1;
    wait_log(4);
    expect_cmd(1, RD, 3, 1, 0, "R10 blocker read");
    expect_cmd(2, RD, 0, 7, 9, "R10 older same-address read first");
    expect_cmd(3, WR, 0, 7, 9, "R10 later write second");

    // R9 age promotion
    age_limit = 8'd5;
    ready_mode = 0; idle(2); log_n = 0;
    push(RD, 4, 1, 0); push(RD, 0, 9, 0);
    idle(10);
    push(RD, 0, 7, 5);
    ready_mode = 1;
    wait_log(8);
    expect_cmd(1, RD, 4, 1, 0, "R9 urgent hit first");
    expect_cmd(2, PRE, 0, 0, 0, "R9 aged miss beats young hit");
    expect_cmd(3, ACT, 0, 9, 0, "R9 aged row opened");
    expect_cmd(4, RD, 0, 9, 0, "R9 aged read");
    expect_cmd(7, RD, 0, 7, 5, "R9 young read last");
    age_limit = '1;
    idle(4);

    // R1 fill to capacity
    ready_mode = 0; idle(2);
    for (int k = 0; k < DEPTH; k++) push(WR, 5, k % 4, k);
    @(negedge clk);
    check(req_ready == 0, "R1 ready low when full", req_ready, 0);
    @(posedge clk); #1;
    ready_mode = 1;
    for (int t = 0; t < 2000 && pend_n > 0; t++) idle(1);
    @(negedge clk);
    check(req_ready == 1, "R1 ready after drain", req_ready, 1);
    check(pend_n == 0, "R2 full queue drained", pend_n, 0);
    @(posedge clk); #1;

    // random mix
    age_limit = 8'd40; ready_mode = 2;
    for (int it = 0; it < 1500; it++) begin
      if ($urandom % 3 != 0)
        push($urandom % 2, $urandom % NB, $urandom % 4, $urandom % 4);
      else idle(1);
    end
    ready_mode = 1;
    for (int t = 0; t < 5000 && pend_n > 0; t++) idle(1);
    check(pend_n == 0, "R2 every request issued", pend_n, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule